// File: doc/BRIEF.md
# Home-Computer Bus Decoder with Video/Sound Control Latch

This block sits between the 16-bit address bus of a small 8-bit home computer's CPU and the memories and peripherals around it. From the address and a bus-valid strobe it works out which region is being accessed. The possible targets are the on-chip register/RAM page, a 4 KB video RAM, a 16 KB expansion window, a video/sound control region and a boot ROM. The ROM also appears a second time, as an alias, directly below its home location. Each target gets its own select line and a region-relative address. Read data from the selected source is steered back onto the CPU data bus. Any access that hits no region reads back as all ones.

The block also owns the write-only video/sound control latch. A write to any address in the control region loads it. The latch drives the speaker bit and the display-mode pins of the display controller, and the internal/external character-set pin is tied to the same latch bit as the third graphics-mode pin. A read of the control region returns the keyboard rows, active low, for the column strobe pattern the CPU currently drives. The display controller's 13-bit address is cut to the 12 bits that the video RAM actually has.

Top module: `hcd_bus_decoder`

## Requirements
- R1: With cpu_valid high, an address in 0x0000-0x00FF asserts cs_onchip only, and a read returns onchip_rdata.
- R2: Addresses 0x0100-0x3FFF assert no select, and a read there returns 0xFF.
- R3: 0x4000-0x4FFF asserts cs_vram only, with vram_addr equal to the low 12 address bits, and a read returns vram_rdata.
- R4: 0x5000-0x8FFF asserts cs_exp only, with exp_addr equal to the address minus 0x5000 (14 bits), and a read returns exp_rdata.
- R5: A valid write to any address in 0x9000-0xBFFF loads the control latch on that clock edge. Any other cycle, including writes to other regions, leaves the latch unchanged.
- R6: Latch fields come from write-data bits as follows: bit 7 gives spk_out, bit 6 gives css_out, bit 5 gives ag_out, bit 4 gives gm_out[0], bit 3 gives gm_out[1] and bit 2 gives gm_out[2]. Bits 1 and 0 are not stored.
- R7: int_ext_out always equals the value held for write-data bit 2, which is the same value as gm_out[2].
- R8: 0xE000-0xFFFF and the alias 0xC000-0xDFFF both assert cs_rom only, with rom_addr equal to the low 13 address bits, so both ranges reach the same ROM byte. A read returns rom_rdata.
- R9: disp_vram_addr equals disp_addr with bit 12 dropped, so display fetches wrap inside 4 KB.
- R10: A read of 0x9000-0xBFFF returns the keyboard rows. Bit r (r < 6) is 0 when some column c has kbd_strobe[c] = 0 and key_down[c*6+r] = 1. Bits 7:6 read as 1.
- R11: While rst_n is low, the latch is cleared, so spk_out, css_out, ag_out, gm_out and int_ext_out are all 0.
- R12: At most one select is active in any cycle, and exactly one is active for every mapped address.
- R13: With cpu_valid low, no select is asserted, cpu_rdata is 0xFF, and writes do not touch the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_valid | input | 1 | Bus cycle valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to CPU |
| onchip_rdata | input | 8 | Read data from on-chip page |
| vram_rdata | input | 8 | Read data from video RAM |
| exp_rdata | input | 8 | Read data from expansion window |
| rom_rdata | input | 8 | Read data from ROM |
| cs_onchip | output | 1 | On-chip page select |
| cs_vram | output | 1 | Video RAM select |
| cs_exp | output | 1 | Expansion window select |
| cs_ctrl | output | 1 | Control region select |
| cs_rom | output | 1 | ROM select (home or alias) |
| vram_addr | output | 12 | Video RAM offset |
| exp_addr | output | 14 | Expansion window offset |
| rom_addr | output | 13 | ROM offset |
| kbd_strobe | input | 8 | Active-low keyboard column strobes |
| key_down | input | 48 | Key matrix, 1 = pressed, index column*6+row |
| disp_addr | input | 13 | Display controller fetch address |
| disp_vram_addr | output | 12 | Wrapped display address to video RAM |
| spk_out | output | 1 | Speaker drive |
| css_out | output | 1 | Colour-set select |
| ag_out | output | 1 | Alpha/graphics select |
| gm_out | output | 3 | Graphics mode pins |
| int_ext_out | output | 1 | Internal/external character-set select |

## Verification
A decode fault shows up in the same cycle as a wrong or doubled select, a wrong region offset, or the wrong byte on cpu_rdata. Because the bench drives different data on every read source each cycle, a mux error cannot hide behind matching values. The control latch is the only state, so a wrong load or a missed hold first shows at the mode outputs half a cycle after the clock edge that should or should not have loaded it, and it persists until the next control write. Writes at the region edges, writes to the ROM alias, and writes made with cpu_valid low are the cases that tell a leaky write enable apart from a correct one.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

   localparam int CPU_AW   = 16;
   localparam int DATA_W   = 8;
   localparam int VRAM_AW  = 12;
   localparam int EXP_AW   = 14;
   localparam int ROM_AW   = 13;
   localparam int DISP_AW  = VRAM_AW + 1;

   localparam logic [CPU_AW-1:0] EXP_BASE = 16'h5000;
   localparam logic [DATA_W-1:0] IDLE_RD  = 8'hFF;

   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_ONCHIP = 3'd1,
      RG_VRAM   = 3'd2,
      RG_EXP    = 3'd3,
      RG_CTRL   = 3'd4,
      RG_ROM    = 3'd5
   } region_e;

   typedef struct packed {
      logic       spk;
      logic       css;
      logic       ag;
      logic [2:0] gm;
   } mode_latch_t;

   localparam mode_latch_t MODE_RESET = '0;

   function automatic mode_latch_t unpack_mode(input logic [DATA_W-1:0] d);
      mode_latch_t m;
      m.spk   = d[7];
      m.css   = d[6];
      m.ag    = d[5];
      m.gm[0] = d[4];
      m.gm[1] = d[3];
      m.gm[2] = d[2];
      return m;
   endfunction

endpackage

// File: rtl/hcd_region_decode.sv
module hcd_region_decode
   import hcd_pkg::*;
#(
   parameter bit ROM_ALIAS = 1'b1
)(
   input  logic [CPU_AW-1:0] addr,
   input  logic              valid,
   output region_e           region
);

   logic page_zero;
   logic alias_ok;

   assign page_zero = (addr[11:8] == 4'h0);

   generate
      if (ROM_ALIAS) begin : g_alias
         assign alias_ok = 1'b1;
      end else begin : g_noalias
         assign alias_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      region = RG_NONE;
      if (valid) begin
         unique case (addr[15:12])
            4'h0:                   region = page_zero ? RG_ONCHIP : RG_NONE;
            4'h4:                   region = RG_VRAM;
            4'h5, 4'h6, 4'h7, 4'h8: region = RG_EXP;
            4'h9, 4'hA, 4'hB:       region = RG_CTRL;
            4'hC, 4'hD:             region = alias_ok ? RG_ROM : RG_NONE;
            4'hE, 4'hF:             region = RG_ROM;
            default:                region = RG_NONE;
         endcase
      end
   end

endmodule

// File: rtl/hcd_ctrl_latch.sv
module hcd_ctrl_latch
   import hcd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   output mode_latch_t       q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= MODE_RESET;
      else if (load)
         q <= unpack_mode(wdata);
   end

endmodule

// File: rtl/hcd_kbd_scan.sv
module hcd_kbd_scan
   import hcd_pkg::*;
#(
   parameter int NCOL = 8,
   parameter int NROW = 6
)(
   input  logic [NCOL-1:0]      strobe_n,
   input  logic [NCOL*NROW-1:0] keys,
   output logic [DATA_W-1:0]    rows_n
);

   generate
      if (NROW < 1 || NROW > DATA_W) begin : g_bad_rows
         $error("hcd_kbd_scan: NROW out of range");
      end
      if (NCOL < 1) begin : g_bad_cols
         $error("hcd_kbd_scan: NCOL out of range");
      end

      for (genvar r = 0; r < DATA_W; r++) begin : g_row
         if (r < NROW) begin : g_live
            logic hit;
            always_comb begin
               hit = 1'b0;
               for (int c = 0; c < NCOL; c++)
                  hit = hit | (~strobe_n[c] & keys[c*NROW + r]);
            end
            assign rows_n[r] = ~hit;
         end else begin : g_pad
            assign rows_n[r] = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/hcd_bus_decoder.sv
module hcd_bus_decoder
   import hcd_pkg::*;
#(
   parameter int NCOL      = 8,
   parameter int NROW      = 6,
   parameter bit ROM_ALIAS = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cpu_addr,
   input  logic                  cpu_valid,
   input  logic                  cpu_wr,
   input  logic [7:0]            cpu_wdata,
   output logic [7:0]            cpu_rdata,
   input  logic [7:0]            onchip_rdata,
   input  logic [7:0]            vram_rdata,
   input  logic [7:0]            exp_rdata,
   input  logic [7:0]            rom_rdata,
   output logic                  cs_onchip,
   output logic                  cs_vram,
   output logic                  cs_exp,
   output logic                  cs_ctrl,
   output logic                  cs_rom,
   output logic [11:0]           vram_addr,
   output logic [13:0]           exp_addr,
   output logic [12:0]           rom_addr,
   input  logic [NCOL-1:0]       kbd_strobe,
   input  logic [NCOL*NROW-1:0]  key_down,
   input  logic [12:0]           disp_addr,
   output logic [11:0]           disp_vram_addr,
   output logic                  spk_out,
   output logic                  css_out,
   output logic                  ag_out,
   output logic [2:0]            gm_out,
   output logic                  int_ext_out
);

   localparam int STROBE_W = 8;

   generate
      if (NCOL > STROBE_W) begin : g_bad_ncol
         $error("hcd_bus_decoder: more columns than strobe lines");
      end
      if (VRAM_AW != 12 || DISP_AW != 13) begin : g_bad_vram
         $error("hcd_bus_decoder: video RAM width mismatch");
      end
   endgenerate

   region_e           region;
   mode_latch_t       mode_q;
   logic [DATA_W-1:0] kbd_rows_n;
   logic [CPU_AW-1:0] exp_off;
   logic              ctrl_load;

   hcd_region_decode #(
      .ROM_ALIAS (ROM_ALIAS)
   ) u_dec (
      .addr   (cpu_addr),
      .valid  (cpu_valid),
      .region (region)
   );

   assign cs_onchip = (region == RG_ONCHIP);
   assign cs_vram   = (region == RG_VRAM);
   assign cs_exp    = (region == RG_EXP);
   assign cs_ctrl   = (region == RG_CTRL);
   assign cs_rom    = (region == RG_ROM);

   assign exp_off   = cpu_addr - EXP_BASE;
   assign vram_addr = cpu_addr[VRAM_AW-1:0];
   assign exp_addr  = exp_off[EXP_AW-1:0];
   assign rom_addr  = cpu_addr[ROM_AW-1:0];

   assign disp_vram_addr = disp_addr[VRAM_AW-1:0];

   assign ctrl_load = cs_ctrl & cpu_wr;

   hcd_ctrl_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctrl_load),
      .wdata (cpu_wdata),
      .q     (mode_q)
   );

   hcd_kbd_scan #(
      .NCOL (NCOL),
      .NROW (NROW)
   ) u_kbd (
      .strobe_n (kbd_strobe),
      .keys     (key_down),
      .rows_n   (kbd_rows_n)
   );

   always_comb begin
      unique case (region)
         RG_ONCHIP: cpu_rdata = onchip_rdata;
         RG_VRAM:   cpu_rdata = vram_rdata;
         RG_EXP:    cpu_rdata = exp_rdata;
         RG_CTRL:   cpu_rdata = kbd_rows_n;
         RG_ROM:    cpu_rdata = rom_rdata;
         default:   cpu_rdata = IDLE_RD;
      endcase
   end

   assign spk_out     = mode_q.spk;
   assign css_out     = mode_q.css;
   assign ag_out      = mode_q.ag;
   assign gm_out      = mode_q.gm;
   assign int_ext_out = mode_q.gm[2];

endmodule

// File: rtl/hcd_bus_decoder_chk.sv
module hcd_bus_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic       cpu_wr,
   input logic [7:0] cpu_wdata,
   input logic [7:0] cpu_rdata,
   input logic       cs_onchip,
   input logic       cs_vram,
   input logic       cs_exp,
   input logic       cs_ctrl,
   input logic       cs_rom,
   input logic       spk_out,
   input logic       css_out,
   input logic       ag_out,
   input logic [2:0] gm_out
);

   logic [4:0] sels;
   logic [5:0] mode_bits;
   assign sels      = {cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom};
   assign mode_bits = {spk_out, css_out, ag_out, gm_out[0], gm_out[1], gm_out[2]};

   // R12
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels));

   // R13
   idle_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |-> (sels == 5'b0));

   // R2
   unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && sels == 5'b0) |-> (cpu_rdata == 8'hFF));

   // R5
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_wr && cs_ctrl) |=> (mode_bits == $past(cpu_wdata[7:2])));

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_valid && cpu_wr && cs_ctrl) |=> $stable(mode_bits));

endmodule

bind hcd_bus_decoder hcd_bus_decoder_chk chk_i (.*);

// File: tb/hcd_bus_decoder_tb.sv
`timescale 1ns/1ps
module hcd_bus_decoder_tb_top;

   localparam int NC = 8;
   localparam int NR = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic              cpu_valid = 1'b0;
   logic              cpu_wr = 1'b0;
   logic [7:0]        cpu_wdata = '0;
   logic [7:0]        cpu_rdata;
   logic [7:0]        onchip_rdata = 8'h11, vram_rdata = 8'h22, exp_rdata = 8'h33, rom_rdata = 8'h44;
   logic              cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom;
   logic [11:0]       vram_addr;
   logic [13:0]       exp_addr;
   logic [12:0]       rom_addr;
   logic [NC-1:0]     kbd_strobe = '1;
   logic [NC*NR-1:0]  key_down = '0;
   logic [12:0]       disp_addr = '0;
   logic [11:0]       disp_vram_addr;
   logic              spk_out, css_out, ag_out, int_ext_out;
   logic [2:0]        gm_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] m_latch = 8'h00;

   always #2.5 clk = ~clk;

   hcd_bus_decoder dut_i (.*);

   // reference: region number 0 none,1 onchip,2 vram,3 exp,4 ctrl,5 rom
   function automatic int ref_region(input logic [15:0] a, input logic v);
      int x = a;
      if (!v) return 0;
      if (x < 'h100)  return 1;
      if (x < 'h4000) return 0;
      if (x < 'h5000) return 2;
      if (x < 'h9000) return 3;
      if (x < 'hC000) return 4;
      return 5;
   endfunction

   function automatic logic [7:0] ref_kbd(input logic [NC-1:0] s, input logic [NC*NR-1:0] k);
      logic [7:0] r = 8'hFF;
      for (int row = 0; row < NR; row++)
         for (int col = 0; col < NC; col++)
            if (!s[col] && k[col*NR+row]) r[row] = 1'b0;
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // latch model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_latch = 8'h00;
      else if (ref_region(cpu_addr, cpu_valid) == 4 && cpu_wr) m_latch = cpu_wdata;
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         int rg;
         string tg;
         logic [4:0] exp_cs;
         logic [7:0] exp_rd;
         logic [15:0] off;
         rg = ref_region(cpu_addr, cpu_valid);
         case (rg)
            1: begin tg = "R1";  exp_rd = onchip_rdata; end
            2: begin tg = "R3";  exp_rd = vram_rdata; end
            3: begin tg = "R4";  exp_rd = exp_rdata; end
            4: begin tg = "R10"; exp_rd = ref_kbd(kbd_strobe, key_down); end
            5: begin tg = "R8";  exp_rd = rom_rdata; end
            default: begin tg = cpu_valid ? "R2" : "R13"; exp_rd = 8'hFF; end
         endcase
         exp_cs = {rg == 1, rg == 2, rg == 3, rg == 4, rg == 5};
         check({cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom} == exp_cs, tg, "selects",
               {cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom}, exp_cs);
         // R12
         check($countones({cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom}) == ((rg != 0) ? 1 : 0),
               "R12", "select count", $countones({cs_onchip, cs_vram, cs_exp, cs_ctrl, cs_rom}), rg != 0);
         check(cpu_rdata == exp_rd, tg, "rdata", cpu_rdata, exp_rd);
         if (rg == 2) check(vram_addr == cpu_addr % 4096, "R3", "vram_addr", vram_addr, cpu_addr % 4096);
         if (rg == 3) begin
            off = cpu_addr - 16'd20480;
            check(exp_addr == off[13:0], "R4", "exp_addr", exp_addr, off[13:0]);
         end
         if (rg == 5) check(rom_addr == cpu_addr % 8192, "R8", "rom_addr", rom_addr, cpu_addr % 8192);
         // R9
         check(disp_vram_addr == disp_addr % 4096, "R9", "disp_vram_addr", disp_vram_addr, disp_addr % 4096);
         // R6 / R11
         tg = rst_n ? "R6" : "R11";
         check({spk_out, css_out, ag_out, gm_out} == {m_latch[7], m_latch[6], m_latch[5], m_latch[2], m_latch[3], m_latch[4]},
               tg, "mode outputs", {spk_out, css_out, ag_out, gm_out},
               {m_latch[7], m_latch[6], m_latch[5], m_latch[2], m_latch[3], m_latch[4]});
         // R7
         check(int_ext_out == m_latch[2], "R7", "int_ext", int_ext_out, m_latch[2]);
      end
   end

   task automatic bus(input logic [15:0] a, input logic v, input logic w, input logic [7:0] d);
      @(posedge clk);
      #1;
      cpu_addr = a; cpu_valid = v; cpu_wr = w; cpu_wdata = d;
      onchip_rdata = 8'($urandom); vram_rdata = 8'($urandom);
      exp_rdata = 8'($urandom); rom_rdata = 8'($urandom);
      kbd_strobe = NC'($urandom); key_down = {16'($urandom), 32'($urandom)};
      disp_addr = 13'($urandom);
   endtask

   initial begin
      repeat (3) @(posedge clk);        // R11 reset state checked while low
      #1 rst_n = 1'b1;
      // R1, R2, R3, R4, R8 boundaries (reads)
      bus(16'h0000, 1, 0, 0); bus(16'h00FF, 1, 0, 0); bus(16'h0100, 1, 0, 0);
      bus(16'h3FFF, 1, 0, 0); bus(16'h4000, 1, 0, 0); bus(16'h4FFF, 1, 0, 0);
      bus(16'h5000, 1, 0, 0); bus(16'h8FFF, 1, 0, 0); bus(16'h9000, 1, 0, 0);
      bus(16'hBFFF, 1, 0, 0); bus(16'hC000, 1, 0, 0); bus(16'hDFFF, 1, 0, 0);
      bus(16'hE000, 1, 0, 0); bus(16'hFFFF, 1, 0, 0); bus(16'hC123, 1, 0, 0);
      bus(16'hE123, 1, 0, 0);
      // R5 writes at region edges and inside
      bus(16'hBFFF, 1, 1, 8'hFF); bus(16'h0000, 1, 0, 0);
      bus(16'h9000, 1, 1, 8'h54); bus(16'h0000, 1, 0, 0);
      bus(16'hA5A5, 1, 1, 8'hA8); bus(16'h0000, 1, 0, 0);
      // R5: writes outside the region must not load
      bus(16'h8FFF, 1, 1, 8'h03); bus(16'hC000, 1, 1, 8'hFC); bus(16'h4000, 1, 1, 8'h24);
      bus(16'h0050, 1, 1, 8'h80); bus(16'h0000, 1, 0, 0);
      // R13: invalid write to control region ignored
      bus(16'hBFFF, 0, 1, 8'h00); bus(16'hBFFF, 0, 0, 8'h00); bus(16'h0000, 1, 0, 0);
      // R7 with bit 2 toggling
      bus(16'hBFFF, 1, 1, 8'h04); bus(16'hBFFF, 1, 0, 0); bus(16'hBFFF, 1, 1, 8'h7B);
      bus(16'h0000, 1, 0, 0);
      // R10 keyboard patterns
      for (int i = 0; i < 40; i++) bus(16'hBFFF - 16'(i * 97), 1, 0, 0);
      // mixed traffic
      for (int i = 0; i < 3000; i++)
         bus(16'($urandom), 1'($urandom % 8 != 0), 1'($urandom), 8'($urandom));
      @(posedge clk);
      #1 rst_n = 1'b0;               // R11 asynchronous clear
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule